// File: doc/BRIEF.md
# Low-Speed USB Packet Serializer

This block sends one packet, held in a small byte buffer, onto the USB D+ and D- lines. A start strobe sets it running with a byte count. The count covers the leading sync byte, which the caller places at buffer address 0. The block reads the buffer through an asynchronous read port, one byte per address, and shifts each byte out least significant bit first. Each bit lasts a fixed number of clocks (ten by default). Every bit is NRZI encoded, and a zero is stuffed into the line after any run of six ones.

Before the first bit, the block drives the idle J state for one bit time. After the last bit it drives single-ended zero for two bit times, then J for one bit time, and then releases the lines. At the release it raises a one-cycle done pulse. If the packet was longer than a bare two-byte handshake, it also raises an address-commit pulse in the same cycle, so that the surrounding logic can adopt a pending device address.

Top module: `lowspeed_pkt_tx`

## Requirements
- R1: A start strobe is accepted on a clock edge where the block is idle. The requested count `nbytes_i` is clamped to the range 2..12: a request below 2 sends 2 bytes, and a request above 12 sends 12 bytes.
- R2: Bytes are read from `rd_addr_o` = 0 upward, and `rd_data_i` must follow `rd_addr_o` within the same cycle. Each byte is sent bit 0 first. Every bit, stuffed or not, occupies exactly 10 clock cycles.
- R3: In the cycle after the accepting edge, the block enters a lead-in bit time of 10 cycles. During the lead-in it drives J (`oe_o`=1, `dp_o`=0, `dm_o`=1).
- R4: NRZI coding: a 0 bit swaps the line between J and K (K is `dp_o`=1, `dm_o`=0), and a 1 bit keeps the previous state. The state before the first bit is J.
- R5: After six consecutive 1 bits, one extra 0 bit (a line transition) is sent, lasting one full bit time. The run of ones continues across byte boundaries, and a stuff bit is also inserted after the last byte when that byte ends the run. The run count is zero at the start of each packet.
- R6: After the final bit, the lines go to SE0 (`oe_o`=1, both low) for 20 cycles, then to J for 10 cycles.
- R7: In the cycle after the J tail, `oe_o`, `dp_o`, `dm_o` and `busy_o` are low, and `done_o` is high for that single cycle.
- R8: `busy_o` is high from the cycle after acceptance until the release. Start strobes that arrive while busy have no effect on the packet or on what follows it.
- R9: `addr_commit_o` pulses together with `done_o` when the clamped count is greater than 2. It stays low for a 2-byte packet.
- R10: After reset, every output is low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| nbytes_i | input | 4 | Byte count including the sync byte |
| rd_addr_o | output | 4 | Buffer read address |
| rd_data_i | input | 8 | Buffer byte at `rd_addr_o` |
| oe_o | output | 1 | Line driver enable |
| dp_o | output | 1 | D+ level |
| dm_o | output | 1 | D- level |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-cycle pulse at bus release |
| addr_commit_o | output | 1 | One-cycle pulse: adopt the pending device address |

## Verification
The hardest cases to reach are stuff bits that fall at a byte boundary and a stuff bit owed after the last byte, just before end-of-packet. A misplaced run counter shows up only in these cases. The bench reaches them by sweeping every value of a trailing data byte behind a fixed run-building byte, and by adding packets of all-ones bytes. It also sweeps every count from 2 to 12 over computed byte patterns. For each packet it compares the line state in the middle of every bit period against a waveform computed independently in the bench.

// File: rtl/lstx_pkg.sv
package lstx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LEAD = 3'd1,
    PH_DATA = 3'd2,
    PH_SE0  = 3'd3,
    PH_TAIL = 3'd4
  } phase_t;

  // Line state after one NRZI bit; lvl_j = 1 means the line is at J.
  function automatic logic nrzi_step(input logic lvl_j, input logic bit_v);
    return bit_v ? lvl_j : ~lvl_j;
  endfunction

  // Run length after one data bit.
  function automatic int unsigned run_step(input int unsigned run, input logic bit_v);
    return bit_v ? run + 1 : 0;
  endfunction

endpackage

// File: rtl/lstx_bit_timer.sv
module lstx_bit_timer #(
  parameter int CLKS_PER_BIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  output logic slot_end_o
);
  localparam int CW = $clog2(CLKS_PER_BIT);

  logic [CW-1:0] cnt_q;

  assign slot_end_o = active_i && (cnt_q == CW'(CLKS_PER_BIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!active_i)   cnt_q <= '0;
    else if (slot_end_o)  cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  // R2: the counter never passes the last cycle of a bit period
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(CLKS_PER_BIT - 1));

endmodule

// File: rtl/lstx_line_coder.sv
module lstx_line_coder
  import lstx_pkg::*;
#(
  parameter int STUFF_RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic data_i,
  input  logic bit_i,
  input  logic stuff_i,
  output logic level_j_o,
  output logic stuff_due_o
);
  localparam int RW = $clog2(STUFF_RUN + 1);

  logic          lvl_q;
  logic [RW-1:0] run_q;

  assign level_j_o   = lvl_q;
  assign stuff_due_o = (run_q == RW'(STUFF_RUN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      run_q <= '0;
    end else if (init_i) begin
      lvl_q <= 1'b1;
      run_q <= '0;
    end else if (stuff_i) begin
      lvl_q <= ~lvl_q;
      run_q <= '0;
    end else if (data_i) begin
      lvl_q <= nrzi_step(lvl_q, bit_i);
      run_q <= RW'(run_step(int'(run_q), bit_i));
    end
  end

  // R5: no run of ones ever exceeds the stuffing limit
  assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(STUFF_RUN));

  // R5: a stuffed bit always makes a transition
  assert_stuff_toggles_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stuff_i && !init_i) |=> (lvl_q != $past(lvl_q)));

  // R4: a zero data bit makes a transition
  assert_zero_toggles_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_i && !bit_i && !stuff_i && !init_i) |=> (lvl_q != $past(lvl_q)));

  // R4: a one data bit keeps the line
  assert_one_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_i && bit_i && !stuff_i && !init_i) |=> $stable(lvl_q));

endmodule

// File: rtl/lstx_sequencer.sv
module lstx_sequencer
  import lstx_pkg::*;
#(
  parameter int MIN_BYTES = 2,
  parameter int MAX_BYTES = 12,
  parameter int SE0_BITS  = 2,
  localparam int PW = $clog2(MAX_BYTES + 1),
  localparam int SW = $clog2(SE0_BITS) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [PW-1:0] nbytes_i,
  input  logic          slot_end_i,
  input  logic          stuff_due_i,
  input  logic [7:0]    rd_data_i,
  output phase_t        phase_o,
  output logic [PW-1:0] rd_addr_o,
  output logic          coder_init_o,
  output logic          coder_data_o,
  output logic          coder_bit_o,
  output logic          coder_stuff_o,
  output logic          done_o,
  output logic          commit_o
);

  function automatic logic [PW-1:0] clamp_len(input logic [PW-1:0] req);
    if (req < PW'(MIN_BYTES)) return PW'(MIN_BYTES);
    if (req > PW'(MAX_BYTES)) return PW'(MAX_BYTES);
    return req;
  endfunction

  phase_t        phase_q;
  logic [PW-1:0] len_q;
  logic [PW-1:0] byte_q;
  logic [2:0]    bit_q;
  logic [SW-1:0] se0_q;
  logic          done_q;
  logic          commit_q;

  // Named internal events
  logic accept, in_stream, more_bits, do_stuff, do_data, go_se0, se0_last, tail_end;

  assign accept    = (phase_q == PH_IDLE) && start_i;
  assign in_stream = ((phase_q == PH_LEAD) || (phase_q == PH_DATA)) && slot_end_i;
  assign more_bits = (byte_q < len_q);
  assign do_stuff  = in_stream && (phase_q == PH_DATA) && stuff_due_i;
  assign do_data   = in_stream && !do_stuff && more_bits;
  assign go_se0    = in_stream && !do_stuff && !more_bits;
  assign se0_last  = (se0_q == SW'(SE0_BITS - 1));
  assign tail_end  = (phase_q == PH_TAIL) && slot_end_i;

  assign phase_o       = phase_q;
  assign rd_addr_o     = byte_q;
  assign coder_init_o  = accept;
  assign coder_data_o  = do_data;
  assign coder_bit_o   = rd_data_i[bit_q];
  assign coder_stuff_o = do_stuff;
  assign done_o        = done_q;
  assign commit_o      = commit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      len_q    <= PW'(MIN_BYTES);
      byte_q   <= '0;
      bit_q    <= '0;
      se0_q    <= '0;
      done_q   <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      commit_q <= 1'b0;
      if (accept) begin
        phase_q <= PH_LEAD;
        len_q   <= clamp_len(nbytes_i);
        byte_q  <= '0;
        bit_q   <= '0;
      end else if (do_data) begin
        phase_q <= PH_DATA;
        bit_q   <= bit_q + 3'd1;
        if (bit_q == 3'd7) byte_q <= byte_q + 1'b1;
      end else if (go_se0) begin
        phase_q <= PH_SE0;
        se0_q   <= '0;
      end else if ((phase_q == PH_SE0) && slot_end_i) begin
        if (se0_last) phase_q <= PH_TAIL;
        else          se0_q   <= se0_q + 1'b1;
      end else if (tail_end) begin
        phase_q  <= PH_IDLE;
        done_q   <= 1'b1;
        commit_q <= (len_q > PW'(MIN_BYTES));
      end
    end
  end

  // R8: the packet length cannot change while a packet is in progress
  assert_len_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> $stable(len_q));

  // R6: SE0 lasts the full number of bit times before the J tail
  assert_se0_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_TAIL) && ($past(phase_q) == PH_SE0)) |-> ($past(se0_q) == SW'(SE0_BITS - 1)));

  // R9: the commit pulse only appears together with done
  assert_commit_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> done_q);

  // R2: the first data bit comes from address 0, bit 0
  assert_first_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_LEAD) && slot_end_i) |-> ((byte_q == '0) && (bit_q == 3'd0)));

  // R1: the clamped length stays inside the legal range
  assert_len_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q >= PW'(MIN_BYTES)) && (len_q <= PW'(MAX_BYTES)));

endmodule

// File: rtl/lowspeed_pkt_tx.sv
module lowspeed_pkt_tx
  import lstx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 10,
  parameter int MIN_BYTES    = 2,
  parameter int MAX_BYTES    = 12,
  parameter int SE0_BITS     = 2,
  parameter int STUFF_RUN    = 6,
  localparam int PW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [PW-1:0] nbytes_i,
  output logic [PW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          oe_o,
  output logic          dp_o,
  output logic          dm_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          addr_commit_o
);

  phase_t phase;
  logic   slot_end, stuff_due, level_j;
  logic   c_init, c_data, c_bit, c_stuff;

  lstx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (phase != PH_IDLE),
    .slot_end_o (slot_end)
  );

  lstx_line_coder #(.STUFF_RUN(STUFF_RUN)) u_coder (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_i      (c_init),
    .data_i      (c_data),
    .bit_i       (c_bit),
    .stuff_i     (c_stuff),
    .level_j_o   (level_j),
    .stuff_due_o (stuff_due)
  );

  lstx_sequencer #(
    .MIN_BYTES (MIN_BYTES),
    .MAX_BYTES (MAX_BYTES),
    .SE0_BITS  (SE0_BITS)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .nbytes_i      (nbytes_i),
    .slot_end_i    (slot_end),
    .stuff_due_i   (stuff_due),
    .rd_data_i     (rd_data_i),
    .phase_o       (phase),
    .rd_addr_o     (rd_addr_o),
    .coder_init_o  (c_init),
    .coder_data_o  (c_data),
    .coder_bit_o   (c_bit),
    .coder_stuff_o (c_stuff),
    .done_o        (done_o),
    .commit_o      (addr_commit_o)
  );

  always_comb begin
    oe_o = 1'b1;
    dp_o = 1'b0;
    dm_o = 1'b0;
    unique case (phase)
      PH_IDLE: oe_o = 1'b0;
      PH_LEAD, PH_TAIL: dm_o = 1'b1;
      PH_DATA: begin
        dp_o = ~level_j;
        dm_o = level_j;
      end
      default: ;
    endcase
  end

  assign busy_o = (phase != PH_IDLE);

  // R3: the lead-in bit is J with the driver on
  assert_lead_is_j_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LEAD) |-> (oe_o && !dp_o && dm_o));

  // R7: at done the bus has been released
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!oe_o && !busy_o && !dp_o && !dm_o));

  // R4: data bits are always differential J or K
  assert_differential_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA) |-> (dp_o != dm_o));

endmodule

// File: tb/test_lowspeed_pkt_tx.sv
`timescale 1ns/1ps
module test_lowspeed_pkt_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] nbytes_i = 4'd0;
  logic [3:0] rd_addr_o;
  logic [7:0] rd_data_i;
  logic       oe_o, dp_o, dm_o, busy_o, done_o, addr_commit_o;

  logic [7:0] mem [0:15];
  logic [3:0] exp_w [0:255];
  int         exp_n;
  int         n_checks = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  assign rd_data_i = mem[rd_addr_o];

  lowspeed_pkt_tx i_lowspeed_pkt_tx (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .nbytes_i(nbytes_i),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .oe_o(oe_o), .dp_o(dp_o),
    .dm_o(dm_o), .busy_o(busy_o), .done_o(done_o), .addr_commit_o(addr_commit_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // {busy, oe, dp, dm} expected in each bit period
  function automatic logic [3:0] code_of(input logic lvl_j);
    return lvl_j ? 4'b1101 : 4'b1110;
  endfunction

  task automatic build_expect(input int n);
    logic lvl;
    int   run;
    lvl = 1'b1; run = 0; exp_n = 0;
    exp_w[exp_n++] = 4'b1101;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 8; k++) begin
        if (!mem[i][k]) begin lvl = ~lvl; run = 0; end
        else run = run + 1;
        exp_w[exp_n++] = code_of(lvl);
        if (run == 6) begin lvl = ~lvl; run = 0; exp_w[exp_n++] = code_of(lvl); end
      end
    end
    exp_w[exp_n++] = 4'b1100;
    exp_w[exp_n++] = 4'b1100;
    exp_w[exp_n++] = 4'b1101;
  endtask

  task automatic run_pkt(input int req, input int inj_slot, input string tag);
    int   n;
    int   bad_slot;
    logic [3:0] bad_act;
    n = (req < 2) ? 2 : ((req > 12) ? 12 : req);
    build_expect(n);
    bad_slot = -1; bad_act = '0;
    @(negedge clk);
    start_i  = 1'b1;
    nbytes_i = req[3:0];
    @(posedge clk);
    for (int s = 0; s < exp_n; s++) begin
      for (int w = 0; w < ((s == 0) ? 5 : 10); w++) begin
        @(negedge clk);
        if (w == 0) start_i = 1'b0;
      end
      if (bad_slot < 0 && {busy_o, oe_o, dp_o, dm_o} != exp_w[s]) begin
        bad_slot = s;
        bad_act  = {busy_o, oe_o, dp_o, dm_o};
      end
      if (s == inj_slot) begin
        start_i  = 1'b1;
        nbytes_i = 4'd5;
      end
    end
    if (bad_slot >= 0)
      $display("FAIL %s waveform slot %0d actual=%0h expected=%0h", tag, bad_slot, bad_act, exp_w[bad_slot]);
    n_checks++;
    if (bad_slot >= 0) n_fail++;
    repeat (6) @(negedge clk);
    start_i = 1'b0;
    chk({oe_o, busy_o, done_o, dp_o, dm_o} == 5'b00100, "R7 release state",
        {oe_o, busy_o, done_o, dp_o, dm_o}, 5'b00100);
    chk(addr_commit_o == (n > 2), "R9 address commit", addr_commit_o, (n > 2));
    @(negedge clk);
    chk({done_o, addr_commit_o} == 2'b00, "R7 single-cycle done", {done_o, addr_commit_o}, 0);
  endtask

  task automatic fill(input int n, input int seed);
    mem[0] = 8'h80;
    for (int i = 1; i < 16; i++) mem[i] = 8'((i * 37 + seed * 91 + 5) & 255);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk({oe_o, dp_o, dm_o, busy_o, done_o, addr_commit_o} == 6'b0,
        "R10 reset outputs", {oe_o, dp_o, dm_o, busy_o, done_o, addr_commit_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({oe_o, busy_o} == 2'b00, "R10 idle after reset", {oe_o, busy_o}, 0);

    // R3 R4 R9: two-byte handshake, no commit
    mem[0] = 8'h80; mem[1] = 8'hD2;
    run_pkt(2, -1, "R3 R4 handshake");

    // R5: runs of ones across byte boundaries
    mem[0] = 8'h80; mem[1] = 8'hFF; mem[2] = 8'hFF; mem[3] = 8'h01;
    run_pkt(4, -1, "R5 stuffing across bytes");

    // R5: last byte ends in six ones, stuff owed before EOP
    mem[0] = 8'h80; mem[1] = 8'hC3; mem[2] = 8'hFC;
    run_pkt(3, -1, "R5 stuff before EOP");

    // R1: clamping of the requested count
    fill(12, 3);
    run_pkt(1, -1, "R1 low clamp");
    run_pkt(15, -1, "R1 high clamp");

    // R8: start while busy is ignored
    fill(12, 7);
    run_pkt(6, 3, "R8 start while busy");
    for (int w = 0; w < 30; w++) begin
      @(negedge clk);
      if (oe_o || busy_o) begin
        chk(1'b0, "R8 no packet after ignored start", {oe_o, busy_o}, 0);
        break;
      end
    end
    chk(!oe_o && !busy_o, "R8 idle after ignored start", {oe_o, busy_o}, 0);

    // R4 R5: every trailing byte value behind a run-building byte
    for (int v = 0; v < 256; v++) begin
      mem[0] = 8'h80; mem[1] = 8'hF8; mem[2] = 8'(v);
      run_pkt(3, -1, "R4 R5 byte sweep");
    end

    // R2: every legal count over two computed patterns
    for (int seed = 0; seed < 2; seed++) begin
      for (int n = 2; n <= 12; n++) begin
        fill(n, seed);
        run_pkt(n, -1, "R2 count sweep");
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule